// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter

This block is a 16-bit count-down timer with a reload value, a small clock prescaler and a sticky zero flag. Software sets it up through a simple synchronous register port. One control word enables it, picks one-shot or periodic behaviour and picks the prescale ratio. It also carries a command bit that copies the reload value into the live count at once. The count moves down by one on each prescaled tick.

In one-shot mode the count stops at zero. In periodic mode it takes the reload value again on the next tick and keeps going. A dedicated output flag goes high when the count steps from one to zero, and it stays high until a clear pulse arrives.

While the block is disabled the count rests at all-ones. Turning the block on therefore never raises the flag early, and the first tick after enabling produces 0xFFFE unless a load is forced.

Top module: `mdc_timer`

## Requirements
- R1: While the enable bit is 0, the count reads 0xFFFF and stays there on every cycle, and the flag does not set.
- R2: A control write with both the enable bit (bit 0) and the force-load bit (bit 4) set copies the reload register into the count on that write's clock edge. It also restarts the prescaler, so the next tick arrives a full prescale period later.
- R3: A force-load bit in a write whose enable bit is 0 leaves the count unchanged. A 0 in the force-load bit has no effect. Reading the control word always returns 0 in bit 4.
- R4: With the mode bit (bit 1) at 0, the count stops at 0x0000 and stays there on later ticks.
- R5: With the mode bit at 1, the tick that finds the count at 0x0000 loads the reload value, and counting continues from there.
- R6: The count decrements by exactly one per tick. The 2-bit field in control bits 3:2 gives one tick every 1, 4, 8 or 16 cycles for codes 0, 1, 2 and 3. The first tick comes that many cycles after enable or force-load.
- R7: The flag sets on the tick that moves the count from 1 to 0 and stays set until a cycle with flag_clr high. If a set and a clear fall on the same cycle, the set wins.
- R8: Turning on the enable bit without force-load starts counting from 0xFFFF (the first tick gives 0xFFFE), and the flag does not rise on the enabling edge.
- R9: Register addresses: 0 is control (bit 0 enable, bit 1 mode, bits 3:2 prescale code, bit 4 force-load), 1 is the reload value, and 2 is the read-only count. rd_data shows the addressed register one cycle after rd_addr. A reload write does not disturb a running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| flag_clr | input | 1 | Clears the zero flag |
| zero_flag | output | 1 | Sticky zero-reached flag |

## Verification
A prescaler holding the wrong phase shifts every later decrement. It shows up on the count readback within one prescale period, at most 16 cycles, and a sweep over every ratio and mode pins that down cycle by cycle. A wrong count or a missed reload shows at the next tick, either as a bad readback value or as the flag rising on the wrong cycle. A wrong hold value while disabled shows as the first value after enabling being something other than 0xFFFE.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic       force_ld;
    logic [1:0] pre_sel;
    logic       periodic;
    logic       enable;
  } ctrl_t;
endpackage

// File: rtl/mdc_regs.sv
module mdc_regs
  import mdc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  count,
  output logic              en_q,
  output logic              mode_q,
  output logic [1:0]        sel_q,
  output logic [CNT_W-1:0]  load_q,
  output logic              fl_pulse,
  output logic              ctrl_wr,
  output logic [CNT_W-1:0]  rd_data
);
  ctrl_t wr_ctrl;

  assign wr_ctrl  = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign fl_pulse = ctrl_wr && wr_ctrl.force_ld && wr_ctrl.enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= 2'd0;
      load_q <= '1;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wr_ctrl.enable;
        mode_q <= wr_ctrl.periodic;
        sel_q  <= wr_ctrl.pre_sel;
      end
      if (wr_en && (wr_addr == ADDR_LOAD)) load_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_CTRL:  rd_data <= CNT_W'({1'b0, sel_q, mode_q, en_q});
        ADDR_LOAD:  rd_data <= load_q;
        ADDR_COUNT: rd_data <= count;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdc_prescaler.sv
module mdc_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] last;

  always_comb begin
    case (sel)
      2'd0:    last = PRE_W'(0);
      2'd1:    last = PRE_W'(3);
      2'd2:    last = PRE_W'(7);
      default: last = PRE_W'(15);
    endcase
  end

  assign tick = en && (phase_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !en) phase_q <= '0;
    else if (tick)             phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/mdc_core.sv
module mdc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             periodic,
  input  logic             tick,
  input  logic             force_ld,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '1;
      flag_q  <= 1'b0;
    end else begin
      if (force_ld)     count_q <= load_val;
      else if (!en)     count_q <= '1;
      else if (tick) begin
        if (count_q == '0) count_q <= periodic ? load_val : count_q;
        else               count_q <= count_q - 1'b1;
      end
      if (en && !force_ld && tick && (count_q == ONE)) flag_q <= 1'b1;
      else if (flag_clr)                                flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdc_timer.sv
module mdc_timer
  import mdc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              flag_clr,
  output logic              zero_flag
);
  logic             en_q, mode_q, fl_pulse, ctrl_wr, tick;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] load_q, count_q;

  mdc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .count(count_q), .en_q(en_q), .mode_q(mode_q),
    .sel_q(sel_q), .load_q(load_q), .fl_pulse(fl_pulse), .ctrl_wr(ctrl_wr),
    .rd_data(rd_data)
  );

  mdc_prescaler #(.PRE_W(4)) u_pre (
    .clk(clk), .rst(rst), .en(en_q), .restart(fl_pulse), .sel(sel_q), .tick(tick)
  );

  mdc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(en_q), .periodic(mode_q), .tick(tick),
    .force_ld(fl_pulse), .load_val(load_q), .flag_clr(flag_clr),
    .count_q(count_q), .flag_q(zero_flag)
  );
endmodule

// File: rtl/mdc_timer_chk.sv
module mdc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             mode_q,
  input logic             tick,
  input logic             fl_pulse,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] count_q,
  input logic             zero_flag
);
  p_hold_ffff_r1: assert property (@(posedge clk) disable iff (rst)
    (!en_q && $past(!en_q)) |-> (count_q == '1));

  p_force_load_r2: assert property (@(posedge clk) disable iff (rst)
    fl_pulse |=> (count_q == $past(load_q)));

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && !mode_q && count_q == '0 && !ctrl_wr) |=> (count_q == '0));

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (en_q && mode_q && tick && count_q == '0 && !ctrl_wr) |=> (count_q == $past(load_q)));

  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick && count_q != '0 && !ctrl_wr) |=> (count_q == $past(count_q) - 1'b1));

  p_flag_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_flag) |-> (count_q == '0));

  p_no_early_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> !$rose(zero_flag));
endmodule

bind mdc_timer mdc_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/mdc_timer_tb.sv
`timescale 1ns/1ps
module mdc_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd2;
  logic [15:0] rd_data;
  logic        flag_clr = 1'b0;
  logic        zero_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdc_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag_clr(flag_clr), .zero_flag(zero_flag)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    @(posedge clk); #1 v = rd_data;
    @(negedge clk);
    rd_addr = 2'd2;
  endtask

  function automatic int ratio(int sel);
    return (sel == 0) ? 1 : (1 << (sel + 1));
  endfunction

  function automatic logic [15:0] ctrl(bit fl, int sel, bit per, bit en);
    return {11'd0, fl, 2'(sel), per, en};
  endfunction

  // Disable, clear the flag, program the reload value, then enable with force-load.
  task automatic setup(int load, int sel, bit per);
    wr(2'd0, 16'h0000);
    flag_clr = 1'b1;
    wr(2'd1, 16'(load));
    flag_clr = 1'b0;
    rd_addr = 2'd2;
    wr(2'd0, ctrl(1'b1, sel, per, 1'b1));
  endtask

  // m counts edges after the load edge; the sample after edge m+1 shows the count after edge m.
  task automatic sweep(int m0, int m1, int load, int n, bit per, string req);
    for (int m = m0; m < m1; m++) begin
      int t;
      int e;
      @(posedge clk); #1;
      t = m / n;
      if (per) e = load - (t % (load + 1));
      else     e = (t >= load) ? 0 : load - t;
      chk(req, rd_data, 16'(e));
      chk("R7", {15'd0, zero_flag}, {15'd0, ((m + 1) / n) >= load});
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset flag", {15'd0, zero_flag}, 16'd0);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R1 reset count", v, 16'hFFFF);

    // R3: force-load without enable does nothing
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0010);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R3 force while disabled", v, 16'hFFFF);

    // R6, R4, R5, R7: sweep ratios, modes and reload values
    for (int sel = 0; sel < 4; sel++)
      for (int per = 0; per < 2; per++)
        for (int li = 0; li < 2; li++) begin
          int load = (li == 0) ? 1 : 3;
          setup(load, sel, per[0]);
          sweep(0, (load + 2) * ratio(sel) * 2, load, ratio(sel), per[0],
                per ? "R5 periodic" : "R4 one-shot");
        end

    // R7: flag stays until cleared
    setup(1, 0, 1'b0);
    sweep(0, 4, 1, 1, 1'b0, "R4");
    repeat (10) @(negedge clk);
    chk("R7 flag held", {15'd0, zero_flag}, 16'd1);
    flag_clr = 1'b1;
    @(posedge clk); #1 chk("R7 flag cleared", {15'd0, zero_flag}, 16'd0);
    @(negedge clk); flag_clr = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 flag stays clear", {15'd0, zero_flag}, 16'd0);

    // R2: force-load mid-count restarts prescaler phase
    setup(100, 3, 1'b0);
    sweep(0, 20, 100, 16, 1'b0, "R6");
    wr(2'd0, ctrl(1'b1, 3, 1'b0, 1'b1));
    sweep(0, 60, 100, 16, 1'b0, "R2");

    // R9: reload write does not disturb the running count
    setup(50, 3, 1'b0);
    wr(2'd1, 16'd7);
    sweep(1, 40, 50, 16, 1'b0, "R9 load write");
    rd(2'd1, v); chk("R9 load readback", v, 16'd7);

    // R3, R9: control readback hides force bit
    wr(2'd0, 16'h001F);
    rd(2'd0, v); chk("R3 ctrl readback", v, 16'h000F);

    // R1: disable mid-count returns to all-ones
    wr(2'd0, 16'h0000);
    repeat (8) @(negedge clk);
    rd(2'd2, v); chk("R1 disabled hold", v, 16'hFFFF);

    // R8, R3: enable without force-load counts from all-ones
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    wr(2'd0, ctrl(1'b0, 0, 1'b0, 1'b1));
    sweep(0, 6, 16'hFFFF, 1, 1'b0, "R8 enable from all-ones");
    wr(2'd0, 16'h0000);
    wr(2'd0, ctrl(1'b0, 2, 1'b0, 1'b1));
    sweep(0, 30, 16'hFFFF, 8, 1'b0, "R8 R6 ratio 8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule